// File: doc/BRIEF.md
# Reorder Buffer Retirement Head with Interrupt Point Selection

This block keeps the retirement end of a reorder buffer. Entries are allocated in program order at the tail, each carrying its program counter and a flag for instructions that must do their commit work only when they are the oldest entry. Execution units report completion by buffer index. Each cycle the block retires, oldest first, the run of completed entries at the head, up to a fixed group width.

An asynchronous interrupt request is held until the oldest unretired entry retires. That entry is the selected instruction. In the cycle it retires, nothing younger retires with it. The block reports the selected program counter and the program counter of the next instruction, which is where the handler will resume. Entries flagged as execute-at-retire hold the head for a fixed commit delay after they complete, even when their work finished long before. Every cycle the block also shows which entry sits at the head. A tally of that trace gives the weight with which each entry would be chosen by an interrupt.

Top module: `rob_retire_head`

## Requirements
- R1: After reset the buffer is empty, `full` is 0, `head_valid` is 0, `retire_cnt` is 0 and `irq_take` is 0.
- R2: In each cycle `retire_cnt` equals the length of the run of completed entries that starts at the head, capped at the group width (4). `retire_mask` bit i is 1 exactly when i < `retire_cnt`.
- R3: While the head entry has not completed, nothing retires, however many younger entries have completed.
- R4: `full` is 1 when DEPTH entries are held. An allocation request while full has no effect: no entry is added and the held entries retire unchanged.
- R5: A completion reported for a slot before that slot is allocated does not mark the later allocation as complete.
- R6: An execute-at-retire entry retires only from the head. Once its completion is visible it holds the head for exactly COMMIT_DLY cycles and retires in the last of them. A retiring group ends just before such an entry when it is not at the head. A completed entry without the flag behaves as if COMMIT_DLY were 1.
- R7: In each cycle `head_valid`, `head_idx` and `head_pc` show the oldest held entry. An entry becomes head one cycle after allocation into an empty buffer, waits w further cycles, and then has a completion issued. It is then shown at the head for w+2 cycles without the flag, or w+1+COMMIT_DLY cycles with it.
- R8: A pulse on `irq_req` is latched. `irq_take` pulses for one cycle, namely the first cycle in which the head retires. In that cycle `retire_cnt` is 1 and `irq_sel_pc` is the head entry's PC.
- R9: With `irq_take`, `irq_samp_pc` is the PC of the entry after the head if one is held, and otherwise the head PC plus PC_STEP.
- R10: An interrupt requested while the buffer is empty stays pending until the first later retirement, and is then taken on that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_pc | input | PC_W | PC of the allocated entry |
| alloc_ear | input | 1 | Entry commits only at the head (execute-at-retire) |
| cmpl_valid | input | 1 | Completion event |
| cmpl_idx | input | $clog2(DEPTH) | Buffer index that completed |
| irq_req | input | 1 | Asynchronous interrupt request pulse |
| full | output | 1 | DEPTH entries are held |
| empty | output | 1 | No entry is held |
| retire_cnt | output | $clog2(RW+1) | Number of entries retiring this cycle |
| retire_mask | output | RW | Retire pulse for each head slot |
| head_valid | output | 1 | A head entry exists |
| head_idx | output | $clog2(DEPTH) | Buffer index of the head |
| head_pc | output | PC_W | PC of the head |
| irq_take | output | 1 | Interrupt taken this cycle |
| irq_sel_pc | output | PC_W | PC of the selected (retiring) instruction |
| irq_samp_pc | output | PC_W | PC reported to the handler |

## Verification
The bench builds the block with DEPTH=8, RW=4, PC_W=16 and COMMIT_DLY=3. With eight slots, every one of the 256 completion patterns over a full buffer can be swept. Each sweep point shows the first and second retire groups, including runs longer than one group. The short commit delay keeps the head-cycle weights of flagged and unflagged entries small enough to sweep over several completion waits. Interrupts are aimed at a blocked head, at a flagged head, at the last held entry and at an empty buffer.

// File: rtl/rob_ret_pkg.sv
package rob_ret_pkg;
  // Length of the run of ones starting at bit 0, limited to lim (lim <= 8).
  function automatic int unsigned lead_run(input logic [7:0] elig, input int unsigned lim);
    int unsigned n;
    bit          go;
    n  = 0;
    go = 1'b1;
    for (int unsigned i = 0; i < 8; i++) begin
      if (go && (i < lim) && elig[i]) n++;
      else go = 1'b0;
    end
    return n;
  endfunction
endpackage

// File: rtl/rob_slot_store.sv
module rob_slot_store #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int RW    = 4,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(RW + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  input  logic [PC_W-1:0]          alloc_pc,
  input  logic                     alloc_ear,
  input  logic                     cmpl_valid,
  input  logic [IW-1:0]            cmpl_idx,
  input  logic [CW-1:0]            ret_n,
  output logic                     full,
  output logic [IW-1:0]            head_idx,
  output logic [RW-1:0]            win_valid,
  output logic [RW-1:0]            win_done,
  output logic [RW-1:0]            win_ear,
  output logic [RW-1:0][PC_W-1:0]  win_pc
);
  localparam int PW = IW + 1;
  localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);

  logic [PC_W-1:0] pc_q [DEPTH];
  logic [DEPTH-1:0] ear_q, done_q;
  logic [PW-1:0] head_q, tail_q, occ;
  logic alloc_fire;

  assign occ        = tail_q - head_q;
  assign full       = (occ == FULL_OCC);
  assign alloc_fire = alloc_valid && !full;
  assign head_idx   = head_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      done_q <= '0;
      ear_q  <= '0;
    end else begin
      if (cmpl_valid) done_q[cmpl_idx] <= 1'b1;
      if (alloc_fire) begin
        done_q[tail_q[IW-1:0]] <= 1'b0;   // a fresh entry starts incomplete
        ear_q[tail_q[IW-1:0]]  <= alloc_ear;
        tail_q <= tail_q + 1'b1;
      end
      head_q <= head_q + PW'(ret_n);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) pc_q[tail_q[IW-1:0]] <= alloc_pc;
  end

  for (genvar i = 0; i < RW; i++) begin : g_win
    logic [IW-1:0] slot;
    assign slot         = head_q[IW-1:0] + IW'(i);
    assign win_valid[i] = (PW'(i) < occ);
    assign win_done[i]  = done_q[slot];
    assign win_ear[i]   = ear_q[slot];
    assign win_pc[i]    = pc_q[slot];
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid) |=> (tail_q == $past(tail_q)));

  assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ <= FULL_OCC));
endmodule

// File: rtl/rob_group_pick.sv
module rob_group_pick #(
  parameter int RW = 4,
  parameter int CW = $clog2(RW + 1)
) (
  input  logic [RW-1:0] win_valid,
  input  logic [RW-1:0] win_done,
  input  logic [RW-1:0] win_ear,
  input  logic          cmt_zero,
  input  logic          irq_pend,
  output logic [CW-1:0] ret_n
);
  import rob_ret_pkg::*;

  logic [RW-1:0] elig;
  logic [7:0]    elig8;
  logic [CW-1:0] run;

  for (genvar i = 0; i < RW; i++) begin : g_elig
    if (i == 0) begin : g_head
      assign elig[i] = win_valid[i] && win_done[i] && (!win_ear[i] || cmt_zero);
    end else begin : g_young
      assign elig[i] = win_valid[i] && win_done[i] && !win_ear[i];
    end
  end

  always_comb begin
    elig8         = '0;
    elig8[RW-1:0] = elig;
    run           = CW'(lead_run(elig8, RW));
    // a pending interrupt lets only the selected head entry retire
    ret_n = (irq_pend && (run != '0)) ? CW'(1) : run;
  end
endmodule

// File: rtl/rob_commit_timer.sv
module rob_commit_timer #(
  parameter int DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic head_ear_done,
  input  logic head_retire,
  output logic cmt_zero
);
  localparam int TW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [TW-1:0] LOAD = TW'(DLY - 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                             left_q <= LOAD;
    else if (head_retire)                   left_q <= LOAD;
    else if (head_ear_done && !cmt_zero)    left_q <= left_q - 1'b1;
  end

  assign cmt_zero = (left_q == '0);
endmodule

// File: rtl/rob_retire_head.sv
module rob_retire_head #(
  parameter int DEPTH      = 16,
  parameter int RW         = 4,
  parameter int PC_W       = 32,
  parameter int COMMIT_DLY = 16,
  parameter int PC_STEP    = 4,
  parameter int IW         = $clog2(DEPTH),
  parameter int CW         = $clog2(RW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic [PC_W-1:0] alloc_pc,
  input  logic            alloc_ear,
  input  logic            cmpl_valid,
  input  logic [IW-1:0]   cmpl_idx,
  input  logic            irq_req,
  output logic            full,
  output logic            empty,
  output logic [CW-1:0]   retire_cnt,
  output logic [RW-1:0]   retire_mask,
  output logic            head_valid,
  output logic [IW-1:0]   head_idx,
  output logic [PC_W-1:0] head_pc,
  output logic            irq_take,
  output logic [PC_W-1:0] irq_sel_pc,
  output logic [PC_W-1:0] irq_samp_pc
);
  logic [RW-1:0]           win_valid, win_done, win_ear;
  logic [RW-1:0][PC_W-1:0] win_pc;
  logic                    cmt_zero, irq_pend_q, head_retire;

  rob_slot_store #(.DEPTH(DEPTH), .PC_W(PC_W), .RW(RW), .IW(IW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_ear(alloc_ear),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .ret_n(retire_cnt),
    .full(full), .head_idx(head_idx),
    .win_valid(win_valid), .win_done(win_done), .win_ear(win_ear), .win_pc(win_pc)
  );

  rob_group_pick #(.RW(RW), .CW(CW)) u_pick (
    .win_valid(win_valid), .win_done(win_done), .win_ear(win_ear),
    .cmt_zero(cmt_zero), .irq_pend(irq_pend_q), .ret_n(retire_cnt)
  );

  rob_commit_timer #(.DLY(COMMIT_DLY)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .head_ear_done(win_valid[0] && win_done[0] && win_ear[0]),
    .head_retire(head_retire), .cmt_zero(cmt_zero)
  );

  assign head_retire = (retire_cnt != '0);
  assign irq_take    = irq_pend_q && head_retire;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pend_q <= 1'b0;
    else        irq_pend_q <= (irq_pend_q && !irq_take) || irq_req;
  end

  for (genvar i = 0; i < RW; i++) begin : g_mask
    assign retire_mask[i] = (CW'(i) < retire_cnt);
  end

  assign empty       = !win_valid[0];
  assign head_valid  = win_valid[0];
  assign head_pc     = win_pc[0];
  assign irq_sel_pc  = win_pc[0];
  assign irq_samp_pc = win_valid[1] ? win_pc[1] : (win_pc[0] + PC_W'(PC_STEP));

  assert_head_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    head_retire |-> (win_valid[0] && win_done[0]));

  assert_ear_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (head_retire && win_ear[0]) |-> cmt_zero);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (retire_cnt == CW'(1)));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_req) |=> !irq_take);
endmodule

// File: tb/sim_rob_retire_head.sv
module sim_rob_retire_head;
  localparam int DEPTH = 8, RW = 4, PC_W = 16, DLY = 3, STEP = 4;
  localparam int IW = $clog2(DEPTH), CW = $clog2(RW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_ear = 1'b0, cmpl_valid = 1'b0, irq_req = 1'b0;
  logic [PC_W-1:0] alloc_pc = '0;
  logic [IW-1:0] cmpl_idx = '0;
  logic full, empty, head_valid, irq_take;
  logic [CW-1:0] retire_cnt;
  logic [RW-1:0] retire_mask;
  logic [IW-1:0] head_idx;
  logic [PC_W-1:0] head_pc, irq_sel_pc, irq_samp_pc;

  int nchk = 0, nfail = 0, ncyc = 0;

  always #4 clk = ~clk;

  rob_retire_head #(.DEPTH(DEPTH), .RW(RW), .PC_W(PC_W), .COMMIT_DLY(DLY), .PC_STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_pc(alloc_pc),
    .alloc_ear(alloc_ear), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .irq_req(irq_req),
    .full(full), .empty(empty), .retire_cnt(retire_cnt), .retire_mask(retire_mask),
    .head_valid(head_valid), .head_idx(head_idx), .head_pc(head_pc), .irq_take(irq_take),
    .irq_sel_pc(irq_sel_pc), .irq_samp_pc(irq_samp_pc)
  );

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", ncyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; alloc_valid = 1'b0; cmpl_valid = 1'b0; irq_req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic alloc(input int pc, input bit ear);
    alloc_valid = 1'b1; alloc_pc = PC_W'(pc); alloc_ear = ear;
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic cmpl(input int idx);
    cmpl_valid = 1'b1; cmpl_idx = IW'(idx);
    step();
    cmpl_valid = 1'b0;
  endtask

  task automatic irq_pulse();
    irq_req = 1'b1;
    step();
    irq_req = 1'b0;
  endtask

  function automatic int mask_of(input int n);
    return (1 << n) - 1;
  endfunction

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 head_valid", int'(head_valid), 0);
    chk("R1 retire_cnt", int'(retire_cnt), 0);
    chk("R1 irq_take", int'(irq_take), 0);

    // R2 R3 R4: exhaustive completion patterns over a full buffer
    for (int m = 0; m < 256; m++) begin
      int run, e1, e2;
      bit go;
      do_reset();
      for (int k = 0; k < DEPTH; k++) alloc(16'h100 + 4 * k, 1'b0);
      chk("R4 full", int'(full), 1);
      alloc(16'hFFF, 1'b0);                       // ignored while full
      for (int k = DEPTH - 1; k >= 1; k--) begin
        if (m[k]) begin
          cmpl(k);
          chk("R3 blocked head", int'(retire_cnt), 0);
        end
      end
      run = 0; go = 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
        if (go && m[k]) run++;
        else go = 1'b0;
      end
      e1 = (run > RW) ? RW : run;
      e2 = ((run - e1) > RW) ? RW : (run - e1);
      if (m[0]) cmpl(0); else step();
      chk("R2 first group", int'(retire_cnt), e1);
      chk("R2 mask", int'(retire_mask), mask_of(e1));
      step();
      chk("R2 second group", int'(retire_cnt), e2);
      chk("R7 head_idx", int'(head_idx), e1);
      if (m == 255) begin
        step();
        chk("R4 drained, no extra entry", int'(empty), 1);
      end
    end

    // R5: completion before allocation does not stick
    do_reset();
    cmpl(1);
    alloc(16'h700, 1'b0); alloc(16'h704, 1'b0); alloc(16'h708, 1'b0);
    cmpl(0);
    chk("R5 stale completion", int'(retire_cnt), 1);

    // R6 R7: head-cycle weights of plain and execute-at-retire entries
    for (int ear = 0; ear < 2; ear++) begin
      for (int w = 0; w < 4; w++) begin
        int cnt, guard;
        do_reset();
        alloc(16'h800, ear[0]);
        cnt = head_valid ? 1 : 0;
        for (int j = 0; j < w; j++) begin
          step();
          if (head_valid) cnt++;
        end
        cmpl(0);
        if (head_valid) cnt++;
        guard = 0;
        while (retire_cnt == '0 && guard < 40) begin
          step();
          if (head_valid) cnt++;
          guard++;
        end
        chk(ear ? "R6 ear head cycles" : "R7 plain head cycles", cnt, w + 1 + (ear ? DLY : 1));
        chk("R7 head_pc", int'(head_pc), 16'h800);
      end
    end

    // R6: group stops before a flagged entry, which then holds the head
    begin
      int cntb, rc, guard;
      do_reset();
      alloc(16'h600, 1'b0); alloc(16'h604, 1'b1); alloc(16'h608, 1'b0);
      cmpl(2); cmpl(1); cmpl(0);
      chk("R6 group stops at flagged", int'(retire_cnt), 1);
      cntb = 0; rc = 0; guard = 0;
      while (guard < 40) begin
        step();
        if (head_valid && head_idx == 1) cntb++;
        guard++;
        if (retire_cnt != '0) begin
          rc = int'(retire_cnt);
          break;
        end
      end
      chk("R6 flagged head cycles", cntb, DLY);
      chk("R6 flagged retire group", rc, 2);
    end

    // R8 R9: interrupt on a blocked head
    do_reset();
    for (int k = 0; k < 6; k++) alloc(16'h200 + 4 * k, 1'b0);
    for (int k = 5; k >= 1; k--) cmpl(k);
    irq_pulse();
    chk("R8 not yet taken", int'(irq_take), 0);
    chk("R3 head blocks", int'(retire_cnt), 0);
    cmpl(0);
    chk("R8 take", int'(irq_take), 1);
    chk("R8 single retire", int'(retire_cnt), 1);
    chk("R8 sel pc", int'(irq_sel_pc), 16'h200);
    chk("R9 samp pc next", int'(irq_samp_pc), 16'h204);
    step();
    chk("R8 one-cycle pulse", int'(irq_take), 0);
    chk("R2 resume group", int'(retire_cnt), 4);
    step();
    chk("R2 last entry", int'(retire_cnt), 1);

    // R9: no following entry held
    do_reset();
    alloc(16'h300, 1'b0);
    irq_pulse();
    cmpl(0);
    chk("R8 take last", int'(irq_take), 1);
    chk("R9 samp pc step", int'(irq_samp_pc), 16'h304);

    // R8 R6: interrupt on a flagged head
    begin
      int guard;
      do_reset();
      alloc(16'h400, 1'b1); alloc(16'h404, 1'b0);
      cmpl(1); cmpl(0);
      irq_pulse();
      guard = 0;
      while (!irq_take && guard < 40) begin
        step();
        guard++;
      end
      chk("R8 flagged take", int'(irq_take), 1);
      chk("R8 flagged sel", int'(irq_sel_pc), 16'h400);
      chk("R9 flagged samp", int'(irq_samp_pc), 16'h404);
      chk("R8 flagged single", int'(retire_cnt), 1);
    end

    // R10: request while empty waits for the first retirement
    do_reset();
    irq_pulse();
    for (int j = 0; j < 3; j++) begin
      chk("R10 no take while empty", int'(irq_take), 0);
      step();
    end
    alloc(16'h500, 1'b0);
    chk("R10 no take before complete", int'(irq_take), 0);
    cmpl(0);
    chk("R10 take", int'(irq_take), 1);
    chk("R10 sel", int'(irq_sel_pc), 16'h500);
    chk("R10 samp", int'(irq_samp_pc), 16'h504);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule